// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the line and frame timing for a raster display. Two counters run on every pixel clock: one for the pixel position within a line and one for the line within a frame. The block decodes them into horizontal and vertical sync pulses, a display-enable window, a display-enable that a blank control can force low, and a vertical-retrace status flag. A pixel-fetch engine or display pipe uses these outputs to pace its data.

Software programs the timing through an 8-bit write port. Horizontal lengths are held in 8-pixel units and vertical lengths in lines. Each length is stored as its count minus one. Timing writes go into a shadow copy, which is moved into the working copy on the last pixel of a frame. Every frame is therefore built from one consistent set of values. The control register (blank and passive-panel select) takes effect on the next clock. After reset the block runs the parameterised default mode, which is 640x480 with an 800-pixel line and a 525-line frame.

Top module: `disp_timing_gen`

## Requirements
- R1: After reset both counters read 0, the parameter default timing is the working set, blank and passive are 0, and the outputs reflect position (0,0).
- R2: With working horizontal active value A (address 0) and blank value B (address 1), `h_pos` counts 0 to (A+1)*8+(B+1)*8-1 and wraps. `de_raw` is 1 on pixels below (A+1)*8 within active lines.
- R3: Horizontal sync is asserted from pixel (A+1)*8+(S+1)*8 for (W+1)*8 pixels. S is the start value at address 2. W is bits 3:0 of address 3.
- R4: The active line count is V+1, where V is a 10-bit value whose low byte is at address 4 and whose bits 9:8 are bits 1:0 of address 5. The frame has V+1 plus (address 6 value)+1 lines. `v_pos` advances on the last pixel of each line and wraps after the last line.
- R5: Vertical sync is asserted from line (V+1)+(T+1) for (U+1) lines. T is the value at address 7. U is bits 3:0 of address 8.
- R6: Bit 7 of address 3 (horizontal) or address 8 (vertical) selects polarity. The pulse is driven high when that bit differs from the passive bit (bit 1 of address 9) and driven low otherwise.
- R7: `vretrace` is 1 exactly while `v_pos` is at or beyond the active line count. It rises and falls only at pixel 0 of a line.
- R8: Bit 0 of address 9 (blank) forces `de` to 0 from the next clock onward. `de_raw`, `hsync` and `vsync` keep running unchanged.
- R9: Timing writes (addresses 0 to 8) have no effect on the outputs until the first pixel of the next frame, where all of them apply together.
- R10: Writes to addresses 10 to 15 change no timing, polarity or control value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Register write data |
| h_pos | output | 13 | Pixel counter within the line |
| v_pos | output | 12 | Line counter within the frame |
| hsync | output | 1 | Horizontal sync at programmed polarity |
| vsync | output | 1 | Vertical sync at programmed polarity |
| de_raw | output | 1 | Display-enable window, ignoring blank |
| de | output | 1 | Display enable, forced low by blank |
| vretrace | output | 1 | Vertical non-display status |

## Verification
The bench reprograms timing in the middle of a frame and checks that the current frame finishes on the old values. A design that applied writes at once would widen the active window on the spot and tear the frame. It flips the passive bit against a set polarity bit, which catches a sync that ignores the panel type and so comes out inverted. It drives blank while comparing sync and `de_raw` against the model, which exposes a blank that also stops sync. It programs the vertical active count above 255 to catch a lost high byte, and writes unmapped addresses to catch address aliasing that would corrupt live timing.

// File: rtl/tg_pkg.sv
package tg_pkg;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 4;
    localparam int HREG_W  = 8;
    localparam int HSHIFT  = 3;
    localparam int VACT_W  = 10;
    localparam int VREG_W  = 8;
    localparam int SYNC_W  = 4;
    localparam int POL_BIT = DATA_W - 1;
    localparam int HCNT_W  = HREG_W + 2 + HSHIFT;
    localparam int VCNT_W  = VACT_W + 2;

    typedef enum logic [ADDR_W-1:0] {
        RA_H_ACT    = 4'd0,
        RA_H_BLK    = 4'd1,
        RA_H_STA    = 4'd2,
        RA_H_SYNC   = 4'd3,
        RA_V_ACT_LO = 4'd4,
        RA_V_ACT_HI = 4'd5,
        RA_V_BLK    = 4'd6,
        RA_V_STA    = 4'd7,
        RA_V_SYNC   = 4'd8,
        RA_CTRL     = 4'd9
    } reg_addr_e;

    typedef struct packed {
        logic [HREG_W-1:0] h_act;
        logic [HREG_W-1:0] h_blk;
        logic [HREG_W-1:0] h_sta;
        logic [SYNC_W-1:0] h_wid;
        logic              h_pol;
        logic [VACT_W-1:0] v_act;
        logic [VREG_W-1:0] v_blk;
        logic [VREG_W-1:0] v_sta;
        logic [SYNC_W-1:0] v_wid;
        logic              v_pol;
    } timing_t;
endpackage

// File: rtl/tg_regs.sv
module tg_regs #(
    parameter int H_ACT_RST = 79,
    parameter int H_BLK_RST = 19,
    parameter int H_STA_RST = 1,
    parameter int H_WID_RST = 11,
    parameter int H_POL_RST = 0,
    parameter int V_ACT_RST = 479,
    parameter int V_BLK_RST = 44,
    parameter int V_STA_RST = 9,
    parameter int V_WID_RST = 1,
    parameter int V_POL_RST = 0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [tg_pkg::ADDR_W-1:0] wr_addr,
    input  logic [tg_pkg::DATA_W-1:0] wr_data,
    input  logic                      frame_load,
    output tg_pkg::timing_t           work_o,
    output logic                      blank_o,
    output logic                      passive_o
);
    import tg_pkg::*;

    typedef struct packed {
        timing_t shd;
        timing_t work;
        logic    blank;
        logic    passive;
    } regs_t;

    regs_t r_d, r_q;

    function automatic timing_t rst_timing();
        timing_t t;
        t.h_act = HREG_W'(H_ACT_RST);
        t.h_blk = HREG_W'(H_BLK_RST);
        t.h_sta = HREG_W'(H_STA_RST);
        t.h_wid = SYNC_W'(H_WID_RST);
        t.h_pol = 1'(H_POL_RST);
        t.v_act = VACT_W'(V_ACT_RST);
        t.v_blk = VREG_W'(V_BLK_RST);
        t.v_sta = VREG_W'(V_STA_RST);
        t.v_wid = SYNC_W'(V_WID_RST);
        t.v_pol = 1'(V_POL_RST);
        return t;
    endfunction

    always_comb begin
        r_d = r_q;
        if (frame_load) r_d.work = r_q.shd;
        if (wr_en) begin
            case (wr_addr)
                RA_H_ACT:    r_d.shd.h_act = wr_data;
                RA_H_BLK:    r_d.shd.h_blk = wr_data;
                RA_H_STA:    r_d.shd.h_sta = wr_data;
                RA_H_SYNC: begin
                    r_d.shd.h_wid = wr_data[SYNC_W-1:0];
                    r_d.shd.h_pol = wr_data[POL_BIT];
                end
                RA_V_ACT_LO: r_d.shd.v_act[DATA_W-1:0] = wr_data;
                RA_V_ACT_HI: r_d.shd.v_act[VACT_W-1:DATA_W] = wr_data[VACT_W-DATA_W-1:0];
                RA_V_BLK:    r_d.shd.v_blk = wr_data;
                RA_V_STA:    r_d.shd.v_sta = wr_data;
                RA_V_SYNC: begin
                    r_d.shd.v_wid = wr_data[SYNC_W-1:0];
                    r_d.shd.v_pol = wr_data[POL_BIT];
                end
                RA_CTRL: begin
                    r_d.blank   = wr_data[0];
                    r_d.passive = wr_data[1];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.shd     <= rst_timing();
            r_q.work    <= rst_timing();
            r_q.blank   <= 1'b0;
            r_q.passive <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign work_o    = r_q.work;
    assign blank_o   = r_q.blank;
    assign passive_o = r_q.passive;

    // R9: working timing only moves at a frame boundary
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_load |=> $stable(r_q.work));
endmodule

// File: rtl/tg_axis.sv
module tg_axis #(
    parameter int CNT_W = 13,
    parameter int SH    = 3,
    parameter int ACT_W = 8,
    parameter int BLK_W = 8,
    parameter int STA_W = 8,
    parameter int WID_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [ACT_W-1:0] act,
    input  logic [BLK_W-1:0] blk,
    input  logic [STA_W-1:0] sta,
    input  logic [WID_W-1:0] wid,
    output logic [CNT_W-1:0] cnt,
    output logic             last,
    output logic             in_act,
    output logic             in_sync
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } axis_t;

    axis_t s_d, s_q;
    logic [CNT_W-1:0] act_len, tot_len, sync_beg, sync_end;

    always_comb begin
        act_len  = (CNT_W'(act) + ONE) << SH;
        tot_len  = act_len + ((CNT_W'(blk) + ONE) << SH);
        sync_beg = act_len + ((CNT_W'(sta) + ONE) << SH);
        sync_end = sync_beg + ((CNT_W'(wid) + ONE) << SH);
        last     = (s_q.cnt == tot_len - ONE);
        in_act   = (s_q.cnt < act_len);
        in_sync  = (s_q.cnt >= sync_beg) && (s_q.cnt < sync_end);
        s_d      = s_q;
        if (step) s_d.cnt = last ? '0 : s_q.cnt + ONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt = s_q.cnt;

    // R2/R4: the counter never leaves the programmed period
    a_r2_r4_bound: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt < tot_len);
    // R2/R4: a step on the last position returns to zero
    a_r2_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (step && last) |=> (s_q.cnt == '0));
    // R3/R5: the sync pulse lies inside the non-display region
    a_r3_r5_sync_in_blank: assert property (@(posedge clk) disable iff (!rst_n)
        in_sync |-> !in_act);
endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen #(
    parameter int H_ACT_RST = 79,
    parameter int H_BLK_RST = 19,
    parameter int H_STA_RST = 1,
    parameter int H_WID_RST = 11,
    parameter int H_POL_RST = 0,
    parameter int V_ACT_RST = 479,
    parameter int V_BLK_RST = 44,
    parameter int V_STA_RST = 9,
    parameter int V_WID_RST = 1,
    parameter int V_POL_RST = 0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [tg_pkg::ADDR_W-1:0] wr_addr,
    input  logic [tg_pkg::DATA_W-1:0] wr_data,
    output logic [tg_pkg::HCNT_W-1:0] h_pos,
    output logic [tg_pkg::VCNT_W-1:0] v_pos,
    output logic                      hsync,
    output logic                      vsync,
    output logic                      de_raw,
    output logic                      de,
    output logic                      vretrace
);
    import tg_pkg::*;

    timing_t work;
    logic    blank, passive;
    logic    h_last, h_act, h_sync;
    logic    v_last, v_act, v_sync;
    logic    frame_load;

    assign frame_load = h_last && v_last;

    tg_regs #(
        .H_ACT_RST(H_ACT_RST), .H_BLK_RST(H_BLK_RST), .H_STA_RST(H_STA_RST),
        .H_WID_RST(H_WID_RST), .H_POL_RST(H_POL_RST),
        .V_ACT_RST(V_ACT_RST), .V_BLK_RST(V_BLK_RST), .V_STA_RST(V_STA_RST),
        .V_WID_RST(V_WID_RST), .V_POL_RST(V_POL_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .frame_load(frame_load),
        .work_o(work), .blank_o(blank), .passive_o(passive)
    );

    tg_axis #(
        .CNT_W(HCNT_W), .SH(HSHIFT), .ACT_W(HREG_W), .BLK_W(HREG_W),
        .STA_W(HREG_W), .WID_W(SYNC_W)
    ) u_hax (
        .clk(clk), .rst_n(rst_n), .step(1'b1),
        .act(work.h_act), .blk(work.h_blk), .sta(work.h_sta), .wid(work.h_wid),
        .cnt(h_pos), .last(h_last), .in_act(h_act), .in_sync(h_sync)
    );

    tg_axis #(
        .CNT_W(VCNT_W), .SH(0), .ACT_W(VACT_W), .BLK_W(VREG_W),
        .STA_W(VREG_W), .WID_W(SYNC_W)
    ) u_vax (
        .clk(clk), .rst_n(rst_n), .step(h_last),
        .act(work.v_act), .blk(work.v_blk), .sta(work.v_sta), .wid(work.v_wid),
        .cnt(v_pos), .last(v_last), .in_act(v_act), .in_sync(v_sync)
    );

    // pulse is driven high when polarity bit and passive select differ
    assign hsync    = (work.h_pol ^ passive) ? h_sync : !h_sync;
    assign vsync    = (work.v_pol ^ passive) ? v_sync : !v_sync;
    assign de_raw   = h_act && v_act;
    assign de       = de_raw && !blank;
    assign vretrace = !v_act;

    // R8: blank always wins over the enable window
    a_r8_blank: assert property (@(posedge clk) disable iff (!rst_n)
        blank |-> !de);
    // R7: retrace starts only at the first pixel of a line
    a_r7_rise_at_line_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vretrace) |-> (h_pos == '0));
    // R7: retrace ends only at the first pixel of a frame
    a_r7_fall_at_frame_start: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vretrace) |-> (h_pos == '0 && v_pos == '0));
endmodule

// File: tb/disp_timing_gen_tb.sv
`timescale 1ns/1ps
module disp_timing_gen_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [12:0] h_pos;
    logic [11:0] v_pos;
    logic hsync, vsync, de_raw, de, vretrace;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // model state: 0 hact,1 hblk,2 hsta,3 hwid,4 hpol,5 vact,6 vblk,7 vsta,8 vwid,9 vpol
    int sh [10];
    int ac [10];
    int m_h, m_v, m_blank, m_pass;

    always #2.5 clk = ~clk;

    disp_timing_gen #(
        .H_ACT_RST(1), .H_BLK_RST(1), .H_STA_RST(0), .H_WID_RST(0), .H_POL_RST(0),
        .V_ACT_RST(3), .V_BLK_RST(3), .V_STA_RST(0), .V_WID_RST(1), .V_POL_RST(0)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .h_pos(h_pos), .v_pos(v_pos), .hsync(hsync), .vsync(vsync),
        .de_raw(de_raw), .de(de), .vretrace(vretrace)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (h=%0d v=%0d)", tag, act, exp, m_h, m_v);
        end
    endtask

    task automatic model_reset();
        int d[10] = '{1, 1, 0, 0, 0, 3, 3, 0, 1, 0};
        for (int k = 0; k < 10; k++) begin sh[k] = d[k]; ac[k] = d[k]; end
        m_h = 0; m_v = 0; m_blank = 0; m_pass = 0;
    endtask

    task automatic model_write(input int a, input int d);
        case (a)
            0: sh[0] = d;
            1: sh[1] = d;
            2: sh[2] = d;
            3: begin sh[3] = d % 16; sh[4] = d / 128; end
            4: sh[5] = (sh[5] / 256) * 256 + d;
            5: sh[5] = (sh[5] % 256) + (d % 4) * 256;
            6: sh[6] = d;
            7: sh[7] = d;
            8: begin sh[8] = d % 16; sh[9] = d / 128; end
            9: begin m_blank = d % 2; m_pass = (d / 2) % 2; end
            default: ;
        endcase
    endtask

    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else begin
            int htot, vtot;
            htot = (ac[0] + ac[1] + 2) * 8;
            vtot = ac[5] + ac[6] + 2;
            if (m_h == htot - 1) begin
                m_h = 0;
                if (m_v == vtot - 1) begin
                    m_v = 0;
                    for (int k = 0; k < 10; k++) ac[k] = sh[k];
                end else m_v++;
            end else m_h++;
            if (wr_en) model_write(int'(wr_addr), int'(wr_data));
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int ha, hb, he, va, vb, ve, in_hs, in_vs, exp_hs, exp_vs, e_raw;
            ha = (ac[0] + 1) * 8;
            hb = ha + (ac[2] + 1) * 8;
            he = hb + (ac[3] + 1) * 8;
            va = ac[5] + 1;
            vb = va + ac[7] + 1;
            ve = vb + ac[8] + 1;
            in_hs = (m_h >= hb && m_h < he) ? 1 : 0;
            in_vs = (m_v >= vb && m_v < ve) ? 1 : 0;
            exp_hs = ((ac[4] ^ m_pass) != 0) ? in_hs : 1 - in_hs;
            exp_vs = ((ac[9] ^ m_pass) != 0) ? in_vs : 1 - in_vs;
            e_raw = (m_h < ha && m_v < va) ? 1 : 0;
            chk("R2 h_pos", int'(h_pos), m_h);
            chk("R4 v_pos", int'(v_pos), m_v);
            chk("R2 de_raw", int'(de_raw), e_raw);
            chk("R8 de", int'(de), (m_blank != 0) ? 0 : e_raw);
            chk("R3/R6 hsync", int'(hsync), exp_hs);
            chk("R5/R6 vsync", int'(vsync), exp_vs);
            chk("R7 vretrace", int'(vretrace), (m_v >= va) ? 1 : 0);
        end
    end

    task automatic wr(input int a, input int d);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_pos(input int h, input int v);
        while (!(m_h == h && m_v == v)) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL R2 watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 h_pos", int'(h_pos), 0);
        chk("R1 v_pos", int'(v_pos), 0);
        chk("R1 de", int'(de), 1);
        chk("R1 hsync", int'(hsync), 1);
        chk("R1 vsync", int'(vsync), 1);
        chk("R1 vretrace", int'(vretrace), 0);
        repeat (600) @(negedge clk);

        // R9: reprogram mid-frame; current frame keeps the old values
        wait_pos(0, 1);
        wr(0, 2); wr(1, 3); wr(2, 1); wr(3, 8'h81);
        wr(4, 2); wr(5, 0); wr(6, 4); wr(7, 1); wr(8, 8'h80);
        wait_pos(20, 2);
        chk("R9 de_raw old width", int'(de_raw), 0);
        wait_pos(20, 0);
        chk("R9 de_raw new width", int'(de_raw), 1);
        repeat (1000) @(negedge clk);

        // R6: passive panel inverts the pulse sense
        wr(9, 2);
        wait_pos(40, 1);
        chk("R6 hsync passive", int'(hsync), 0);
        repeat (500) @(negedge clk);

        // R8: blank forces de low, timing keeps running
        wr(9, 3);
        wait_pos(0, 0);
        chk("R8 de blanked", int'(de), 0);
        chk("R8 de_raw running", int'(de_raw), 1);
        repeat (500) @(negedge clk);
        wr(9, 2);

        // R10: unmapped addresses leave everything unchanged
        wr(12, 8'hFF); wr(10, 8'h00); wr(15, 8'h7F); wr(13, 8'h03);
        repeat (500) @(negedge clk);
        wait_pos(23, 1);
        chk("R10 de_raw last active", int'(de_raw), 1);
        wait_pos(24, 1);
        chk("R10 de_raw first blank", int'(de_raw), 0);
        chk("R10 de unblanked", int'(de), 0);
        wait_pos(40, 2);
        chk("R10 hsync unchanged", int'(hsync), 0);

        // R4: vertical active count above 255 via the high field
        wr(5, 1);
        repeat (16000) @(negedge clk);
        wait_pos(0, 258);
        chk("R4 last active line", int'(vretrace), 0);
        wait_pos(0, 259);
        chk("R4 retrace after 259 lines", int'(vretrace), 1);
        repeat (100) @(negedge clk);
        finish_run();
    end
endmodule